// File: doc/BRIEF.md
# Event Pending Register Bank with Interrupt Output

This block gathers one-cycle event pulses from as many as 96 peripheral sources into three 32-bit pending registers and holds an interrupt request high while any pending bit is set. Each event is named by a 7-bit number. The upper two bits pick one of the three registers, and the lower five bits pick the bit inside it. Software looks at the registers through a small read/write port. It clears bits by writing ones to them. A hardware clear port, which also takes an event number, lets a peripheral withdraw its own pending event.

Bit 0 of register 1 is event 32, and it belongs to the disk interface. Software cannot clear this bit. Only the owning peripheral can clear it, through the hardware clear port. When a raise lands on a bit in the same cycle as any clear of that bit, the raise wins.

Top module: `evt_pend_mux`

## Requirements
- R1: After reset, all 96 pending bits read as zero and `irq` is low.
- R2: A pulse on `raise_vld` with `raise_num` = n, where n[6:5] is 0, 1 or 2, sets bit n[4:0] of register n[6:5] at the next clock edge. Numbers with n[6:5] = 3 change nothing.
- R3: A write with `reg_sel` set to 0, 1 or 2 clears every pending bit of that register whose position holds a one in `reg_wdata`. Bits written as zero keep their value.
- R4: A software write never clears bit 0 of register 1 (event 32), whatever value is written.
- R5: A pulse on `hclr_vld` with `hclr_num` = n clears only the single bit that n selects. This includes the protected bit of R4.
- R6: If a raise and a clear of the same bit (software or hardware) arrive in the same cycle, the bit is set after the edge.
- R7: `irq` is the OR of all pending bits. It rises in the cycle after a raise and falls in the cycle after the last set bit clears.
- R8: `reg_rdata` shows the register picked by `reg_sel` in the same cycle, and reading has no side effects. `reg_sel` = 3 reads as zero, and writes with `reg_sel` = 3 change nothing.
- R9: A hardware clear whose number has n[6:5] = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld | input | 1 | One-cycle event pulse |
| raise_num | input | 7 | Number of the event being raised |
| hclr_vld | input | 1 | One-cycle hardware clear request |
| hclr_num | input | 7 | Number of the event to withdraw |
| reg_wr | input | 1 | Write strobe (write-one-to-clear) |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 32 | Clear mask for the write |
| reg_rdata | output | 32 | Contents of the selected register |
| irq | output | 1 | High while any bit is pending |

## Verification
The hardest situations to reach from the ports are collisions in a single cycle: a raise and a clear of the same bit, and a software write of all ones to register 1 while the protected bit is pending. The vector table drives both edges of each collision in one clock. It then reads every register with writes off, so the winning value shows at the read port. The bench also checks that `irq` stays low before the raising edge and drops only after the last clear.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned EVT_NUM_W  = 7;
  localparam int unsigned EVT_BANK_W = 32;
  localparam int unsigned EVT_BANKS  = 3;
  localparam int unsigned EVT_POS_W  = $clog2(EVT_BANK_W);
  localparam int unsigned EVT_SEL_W  = EVT_NUM_W - EVT_POS_W;
  // Register and bit that software may not clear (event 32)
  localparam int unsigned EVT_LOCK_BANK = 1;
  localparam int unsigned EVT_LOCK_BIT  = 0;
endpackage

// File: rtl/evt_decode.sv
module evt_decode #(
  parameter int unsigned NUM_W = 7,
  parameter int unsigned WIDTH = 32,
  parameter int unsigned BANKS = 3
) (
  input  logic                     vld,
  input  logic [NUM_W-1:0]         num,
  output logic [BANKS*WIDTH-1:0]   hit,
  output logic                     in_range
);
  localparam int unsigned POS_W = $clog2(WIDTH);
  localparam int unsigned SEL_W = NUM_W - POS_W;

  function automatic logic [SEL_W-1:0] bank_of(input logic [NUM_W-1:0] n);
    return n[NUM_W-1:POS_W];
  endfunction

  function automatic logic [POS_W-1:0] pos_of(input logic [NUM_W-1:0] n);
    return n[POS_W-1:0];
  endfunction

  function automatic logic [WIDTH-1:0] onehot(input logic [POS_W-1:0] p);
    return WIDTH'(1) << p;
  endfunction

  assign in_range = (32'(bank_of(num)) < BANKS);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign hit[b*WIDTH +: WIDTH] =
      (vld && (bank_of(num) == SEL_W'(b))) ? onehot(pos_of(num)) : '0;
  end
endmodule

// File: rtl/evt_clr_mask.sv
module evt_clr_mask #(
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned BANKS     = 3,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned LOCK_BANK = 1,
  parameter int unsigned LOCK_BIT  = 0
) (
  input  logic                   wr_en,
  input  logic [SEL_W-1:0]       sel,
  input  logic [WIDTH-1:0]       data,
  output logic [BANKS*WIDTH-1:0] clr
);
  localparam logic [WIDTH-1:0] LOCK_KEEP = ~(WIDTH'(1) << LOCK_BIT);
  localparam logic [WIDTH-1:0] ALL_ONES  = {WIDTH{1'b1}};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam logic [WIDTH-1:0] ALLOW = (b == LOCK_BANK) ? LOCK_KEEP : ALL_ONES;
    assign clr[b*WIDTH +: WIDTH] =
      (wr_en && (sel == SEL_W'(b))) ? (data & ALLOW) : '0;
  end
endmodule

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set,
  input  logic [WIDTH-1:0] sw_clr,
  input  logic [WIDTH-1:0] hw_clr,
  output logic [WIDTH-1:0] pend
);
  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] kill;
  logic [WIDTH-1:0] clash;

  // A raise beats any clear aimed at the same bit
  assign kill  = (sw_clr | hw_clr) & ~set;
  assign clash = set & (sw_clr | hw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~kill) | set;
  end

  assign pend = pend_q;

  p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((pend & $past(set)) == $past(set)));

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|kill) |=> ((pend & $past(kill)) == '0));

  p_raise_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|clash) |=> ((pend & $past(clash)) == $past(clash)));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (~|(set | sw_clr | hw_clr)) |=> $stable(pend));
endmodule

// File: rtl/evt_pend_mux.sv
module evt_pend_mux
  import evt_pkg::*;
#(
  parameter int unsigned NUM_W     = EVT_NUM_W,
  parameter int unsigned WIDTH     = EVT_BANK_W,
  parameter int unsigned BANKS     = EVT_BANKS,
  parameter int unsigned SEL_W     = EVT_SEL_W,
  parameter int unsigned LOCK_BANK = EVT_LOCK_BANK,
  parameter int unsigned LOCK_BIT  = EVT_LOCK_BIT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_vld,
  input  logic [NUM_W-1:0] raise_num,
  input  logic             hclr_vld,
  input  logic [NUM_W-1:0] hclr_num,
  input  logic             reg_wr,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  output logic             irq
);
  localparam int unsigned TOTAL    = BANKS * WIDTH;
  localparam int unsigned LOCK_IDX = LOCK_BANK * WIDTH + LOCK_BIT;

  logic [TOTAL-1:0] set_vec;
  logic [TOTAL-1:0] hclr_vec;
  logic [TOTAL-1:0] sclr_vec;
  logic [TOTAL-1:0] pend_vec;
  logic             raise_in_range;
  logic             hclr_in_range;

  evt_decode #(.NUM_W(NUM_W), .WIDTH(WIDTH), .BANKS(BANKS)) u_raise_dec (
    .vld(raise_vld), .num(raise_num), .hit(set_vec), .in_range(raise_in_range));

  evt_decode #(.NUM_W(NUM_W), .WIDTH(WIDTH), .BANKS(BANKS)) u_hclr_dec (
    .vld(hclr_vld), .num(hclr_num), .hit(hclr_vec), .in_range(hclr_in_range));

  evt_clr_mask #(.WIDTH(WIDTH), .BANKS(BANKS), .SEL_W(SEL_W),
                 .LOCK_BANK(LOCK_BANK), .LOCK_BIT(LOCK_BIT)) u_sw_mask (
    .wr_en(reg_wr), .sel(reg_sel), .data(reg_wdata), .clr(sclr_vec));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    evt_pend_bank #(.WIDTH(WIDTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set   (set_vec [b*WIDTH +: WIDTH]),
      .sw_clr(sclr_vec[b*WIDTH +: WIDTH]),
      .hw_clr(hclr_vec[b*WIDTH +: WIDTH]),
      .pend  (pend_vec[b*WIDTH +: WIDTH]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (reg_sel == SEL_W'(b)) reg_rdata = pend_vec[b*WIDTH +: WIDTH];
    end
  end

  assign irq = |pend_vec;

  p_irq_after_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && raise_in_range) |=> irq);

  p_lock_bit_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_sel == SEL_W'(LOCK_BANK)) && pend_vec[LOCK_IDX] && !hclr_vec[LOCK_IDX])
      |=> pend_vec[LOCK_IDX]);

  p_hclr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hclr_vld |-> ($countones(hclr_vec) <= 1));

  p_raise_oob_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_vld && !raise_in_range) |-> (set_vec == '0));

  p_hclr_oob_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hclr_vld && !hclr_in_range) |-> (hclr_vec == '0));

  p_read_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !raise_vld && !hclr_vld) |=> $stable(pend_vec));
endmodule

// File: tb/evt_pend_mux_tb.sv
`timescale 1ns/1ps
module evt_pend_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raise_vld = 1'b0;
  logic [6:0]  raise_num = '0;
  logic        hclr_vld = 1'b0;
  logic [6:0]  hclr_num = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  evt_pend_mux u_dut (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_num(raise_num),
    .hclr_vld(hclr_vld), .hclr_num(hclr_num), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  typedef struct packed {
    logic [3:0]  req;
    logic        rv;
    logic [6:0]  rn;
    logic        hv;
    logic [6:0]  hn;
    logic        we;
    logic [1:0]  sel;
    logic [31:0] wd;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
    logic        eirq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 1'b1, 7'd5,   1'b0, 7'd0,   1'b0, 2'd0, 32'h0,        32'h20,  32'h0,   32'h0,        1'b1}, // R2 raise 5
    '{4'd2, 1'b1, 7'd37,  1'b0, 7'd0,   1'b0, 2'd0, 32'h0,        32'h20,  32'h20,  32'h0,        1'b1}, // R2 raise 37
    '{4'd2, 1'b1, 7'd32,  1'b0, 7'd0,   1'b0, 2'd0, 32'h0,        32'h20,  32'h21,  32'h0,        1'b1}, // R2 raise 32
    '{4'd2, 1'b1, 7'd95,  1'b0, 7'd0,   1'b0, 2'd0, 32'h0,        32'h20,  32'h21,  32'h80000000, 1'b1}, // R2 raise 95
    '{4'd2, 1'b1, 7'd99,  1'b0, 7'd0,   1'b0, 2'd0, 32'h0,        32'h20,  32'h21,  32'h80000000, 1'b1}, // R2 bank 3 ignored
    '{4'd4, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd1, 32'hFFFFFFFF, 32'h20,  32'h1,   32'h80000000, 1'b1}, // R4 lock bit survives
    '{4'd6, 1'b1, 7'd0,   1'b0, 7'd0,   1'b1, 2'd0, 32'h1,        32'h21,  32'h1,   32'h80000000, 1'b1}, // R6 raise beats write
    '{4'd3, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd0, 32'h20,       32'h1,   32'h1,   32'h80000000, 1'b1}, // R3 partial clear
    '{4'd8, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd3, 32'hFFFFFFFF, 32'h1,   32'h1,   32'h80000000, 1'b1}, // R8 write sel 3 ignored
    '{4'd5, 1'b0, 7'd0,   1'b1, 7'd32,  1'b0, 2'd0, 32'h0,        32'h1,   32'h0,   32'h80000000, 1'b1}, // R5 hw clear of lock bit
    '{4'd9, 1'b0, 7'd0,   1'b1, 7'd127, 1'b0, 2'd0, 32'h0,        32'h1,   32'h0,   32'h80000000, 1'b1}, // R9 hw clear bank 3
    '{4'd6, 1'b1, 7'd10,  1'b1, 7'd10,  1'b0, 2'd0, 32'h0,        32'h401, 32'h0,   32'h80000000, 1'b1}, // R6 raise beats hw clear
    '{4'd5, 1'b0, 7'd0,   1'b1, 7'd10,  1'b0, 2'd0, 32'h0,        32'h1,   32'h0,   32'h80000000, 1'b1}, // R5 single bit cleared
    '{4'd3, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd2, 32'h80000000, 32'h1,   32'h0,   32'h0,        1'b1}, // R3 clear bank 2
    '{4'd7, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd0, 32'h1,        32'h0,   32'h0,   32'h0,        1'b0}, // R7 last bit, irq drops
    '{4'd7, 1'b1, 7'd40,  1'b1, 7'd33,  1'b0, 2'd0, 32'h0,        32'h0,   32'h100, 32'h0,        1'b1}, // R7 irq rises again
    '{4'd3, 1'b0, 7'd0,   1'b0, 7'd0,   1'b1, 2'd1, 32'h100,      32'h0,   32'h0,   32'h0,        1'b0}  // R3 clear bank 1
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s;
    #0.5;
    v = reg_rdata;
  endtask

  task automatic idle_inputs();
    raise_vld = 1'b0; hclr_vld = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic check_all(input string tag, input logic [31:0] e0, e1, e2, input logic ei);
    logic [31:0] v;
    read_reg(2'd0, v); check({tag, " reg0"}, v, e0);
    read_reg(2'd1, v); check({tag, " reg1"}, v, e1);
    read_reg(2'd2, v); check({tag, " reg2"}, v, e2);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, ei});
  endtask

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_all("R1 reset", 32'h0, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      raise_vld = VECS[i].rv; raise_num = VECS[i].rn;
      hclr_vld  = VECS[i].hv; hclr_num  = VECS[i].hn;
      reg_wr    = VECS[i].we; reg_sel   = VECS[i].sel; reg_wdata = VECS[i].wd;
      @(posedge clk);
      #1;
      idle_inputs();
      check_all($sformatf("R%0d vec%0d", VECS[i].req, i),
                VECS[i].e0, VECS[i].e1, VECS[i].e2, VECS[i].eirq);
    end

    // R7: irq stays low before the raising edge, high after it
    @(negedge clk);
    raise_vld = 1'b1; raise_num = 7'd66;
    #1;
    check("R7 irq before edge", {31'd0, irq}, 32'd0);
    @(posedge clk);
    #1;
    idle_inputs();
    check("R7 irq after edge", {31'd0, irq}, 32'd1);

    // R8: reads change nothing, select 3 reads zero
    read_reg(2'd2, v); check("R8 read bank2", v, 32'h4);
    read_reg(2'd3, v); check("R8 sel3 zero", v, 32'h0);
    repeat (2) @(posedge clk);
    #1;
    read_reg(2'd2, v); check("R8 reread bank2", v, 32'h4);

    // R1: reset during operation wipes pending bits
    @(negedge clk);
    raise_vld = 1'b1; raise_num = 7'd32;
    @(posedge clk);
    #1;
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check_all("R1 midrun reset", 32'h0, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule